// File: doc/BRIEF.md
# Laser Transmitter Safety Shutdown Controller

This synchronous block decides, every clock, whether a laser transmitter may drive its modulation and bias currents. Three things can stop the drive. The first is a complementary pair of shutdown inputs. The second is an inactivity watchdog that sees no edge on the serial transmit data for longer than a programmable number of cycles. The third is a reset. When the drive is stopped, both enables drop and a separate output pulls the bias control loop low.

The block also produces a complementary laser-alarm pair. In normal operation the alarm reports the two out-of-range flags of a digitised bias-monitor window comparison. While the drive is stopped, a mask-select input fixes the alarm. A high select forces the alarm high. A low select holds the alarm low.

The transmit data passes through a two-flop synchroniser before edge detection. The idle limit is held in a register. Reset loads it from a parameter, and a load strobe can replace it from an input port. All outputs are registered.

Top module: `laser_safety_ctrl`

## Requirements
- R1: While rst_n is low, mod_en and bias_en are 0, loop_pull_low is 1, alarm is 0 and alarm_n is 1.
- R2: Drive is allowed only when shdn_a is 0 and shdn_b is 1. Any other pair value forces mod_en and bias_en to 0 one clock later.
- R3: mod_en always equals bias_en, and loop_pull_low is always the inverse of bias_en.
- R4: With wdog_dis at 0 and idle limit L, suppose tx_data last changed before clock edge T. The enables stay 1 through edge T+L+3 and are 0 from edge T+L+4.
- R5: A rising edge and a falling edge of tx_data both restart the idle count. After an idle shutdown, a change of tx_data before edge T re-enables drive at edge T+3. Coming out of reset, the block counts as idle until the first data change.
- R6: While wdog_dis is 1, inactivity never turns drive off, so the pair inputs alone decide.
- R7: After reset the idle limit is DEF_LIMIT. When limit_load is 1 at a clock edge, idle_limit becomes the new limit from that edge on.
- R8: While drive is allowed, alarm is 1 one clock after mon_hi or mon_lo is 1, and 0 one clock after both are 0.
- R9: While drive is stopped, alarm is 1 one clock later if mask_sel is 1, and 0 if mask_sel is 0, whatever the monitor flags are.
- R10: Outside reset, alarm_n is always the inverse of alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 1 | Serial transmit data watched for edges |
| shdn_a | input | 1 | Shutdown request, high stops drive |
| shdn_b | input | 1 | Complementary shutdown input, must be high to allow drive |
| wdog_dis | input | 1 | High turns the inactivity watchdog off |
| limit_load | input | 1 | Loads idle_limit into the limit register |
| idle_limit | input | CNT_W | New idle limit in clock cycles |
| mon_hi | input | 1 | Bias monitor above upper window threshold |
| mon_lo | input | 1 | Bias monitor below lower window threshold |
| mask_sel | input | 1 | Alarm level during shutdown: 1 forces high, 0 holds low |
| mod_en | output | 1 | Modulation current enable |
| bias_en | output | 1 | Bias current enable |
| loop_pull_low | output | 1 | Pulls the bias control loop output low |
| alarm | output | 1 | Laser alarm |
| alarm_n | output | 1 | Inverse of alarm |

## Verification
The hardest situation to reach is the exact cycle at which an idle shutdown begins or ends. That cycle depends on the synchroniser latency and on whichever limit is loaded at the time. The stimulus loads a short limit through the port and toggles the data with alternating polarity at fixed spacings. It then stops the data and samples the enables one edge before and one edge after the predicted boundary. The default limit is exercised once, straight out of reset, with the same two-sided check.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    typedef struct packed {
        logic mod_en;
        logic bias_en;
        logic pull_low;
        logic alarm;
        logic alarm_n;
    } lsc_out_t;

    localparam lsc_out_t LSC_OUT_RESET = '{
        mod_en:   1'b0,
        bias_en:  1'b0,
        pull_low: 1'b1,
        alarm:    1'b0,
        alarm_n:  1'b1
    };
endpackage

// File: rtl/lsc_edge_sync.sv
module lsc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_seen
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // compare last synchronised sample with the one before it
    assign edge_seen = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];
endmodule

// File: rtl/lsc_idle_timer.sv
module lsc_idle_timer #(
    parameter int          CNT_W     = 16,
    parameter logic [CNT_W-1:0] DEF_LIMIT = 16'd1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_seen,
    input  logic             limit_load,
    input  logic [CNT_W-1:0] idle_limit,
    output logic             idle
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] limit;
        logic             idle;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (limit_load) st_d.limit = idle_limit;
        if (edge_seen) begin
            st_d.cnt  = '0;
            st_d.idle = 1'b0;
        end else if (st_q.cnt >= st_q.limit) begin
            st_d.idle = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.limit <= DEF_LIMIT;
            st_q.idle  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle = st_q.idle;
endmodule

// File: rtl/laser_safety_ctrl.sv
module laser_safety_ctrl
    import lsc_pkg::*;
#(
    parameter int               CNT_W       = 16,
    parameter logic [CNT_W-1:0] DEF_LIMIT   = 16'd1000,
    parameter int               SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_data,
    input  logic             shdn_a,
    input  logic             shdn_b,
    input  logic             wdog_dis,
    input  logic             limit_load,
    input  logic [CNT_W-1:0] idle_limit,
    input  logic             mon_hi,
    input  logic             mon_lo,
    input  logic             mask_sel,
    output logic             mod_en,
    output logic             bias_en,
    output logic             loop_pull_low,
    output logic             alarm,
    output logic             alarm_n
);
    logic data_edge;
    logic idle;

    lsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (tx_data),
        .edge_seen (data_edge)
    );

    lsc_idle_timer #(.CNT_W(CNT_W), .DEF_LIMIT(DEF_LIMIT)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_seen  (data_edge),
        .limit_load (limit_load),
        .idle_limit (idle_limit),
        .idle       (idle)
    );

    lsc_out_t out_d, out_q;
    logic     pair_ok, allow;

    always_comb begin
        pair_ok = !shdn_a && shdn_b;
        allow   = pair_ok && !(idle && !wdog_dis);
        out_d.mod_en   = allow;
        out_d.bias_en  = allow;
        out_d.pull_low = !allow;
        out_d.alarm    = allow ? (mon_hi || mon_lo) : mask_sel;
        out_d.alarm_n  = !out_d.alarm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= LSC_OUT_RESET;
        else        out_q <= out_d;
    end

    assign mod_en        = out_q.mod_en;
    assign bias_en       = out_q.bias_en;
    assign loop_pull_low = out_q.pull_low;
    assign alarm         = out_q.alarm;
    assign alarm_n       = out_q.alarm_n;
endmodule

// File: rtl/laser_safety_ctrl_checker.sv
module laser_safety_ctrl_checker (
    input logic clk,
    input logic rst_n,
    input logic shdn_a,
    input logic shdn_b,
    input logic wdog_dis,
    input logic mon_hi,
    input logic mon_lo,
    input logic mask_sel,
    input logic mod_en,
    input logic bias_en,
    input logic loop_pull_low,
    input logic alarm,
    input logic alarm_n
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!mod_en && !bias_en && loop_pull_low && !alarm && alarm_n) || !rst_n);

    assert_pair_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_a || !shdn_b) |=> (!mod_en && !bias_en));

    assert_enables_tied_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en == bias_en) && (loop_pull_low == !bias_en));

    assert_wdog_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_dis && !shdn_a && shdn_b) |=> mod_en);

    assert_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_dis && !shdn_a && shdn_b) |=> (alarm == $past(mon_hi || mon_lo)));

    assert_mask_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_a && mask_sel) |=> alarm);

    assert_mask_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_a && !mask_sel) |=> !alarm);

    assert_complement_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_n == !alarm);
endmodule

bind laser_safety_ctrl laser_safety_ctrl_checker u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .shdn_a        (shdn_a),
    .shdn_b        (shdn_b),
    .wdog_dis      (wdog_dis),
    .mon_hi        (mon_hi),
    .mon_lo        (mon_lo),
    .mask_sel      (mask_sel),
    .mod_en        (mod_en),
    .bias_en       (bias_en),
    .loop_pull_low (loop_pull_low),
    .alarm         (alarm),
    .alarm_n       (alarm_n)
);

// File: tb/laser_safety_ctrl_bench.sv
module laser_safety_ctrl_bench;
    localparam int CNT_W = 16;
    localparam int DEF_L = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_data = 1'b0, shdn_a = 1'b0, shdn_b = 1'b1, wdog_dis = 1'b0;
    logic limit_load = 1'b0;
    logic [CNT_W-1:0] idle_limit = '0;
    logic mon_hi = 1'b0, mon_lo = 1'b0, mask_sel = 1'b0;
    logic mod_en, bias_en, loop_pull_low, alarm, alarm_n;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;

    laser_safety_ctrl #(.CNT_W(CNT_W), .DEF_LIMIT(16'(DEF_L))) u_laser_safety_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .shdn_a(shdn_a), .shdn_b(shdn_b),
        .wdog_dis(wdog_dis), .limit_load(limit_load), .idle_limit(idle_limit),
        .mon_hi(mon_hi), .mon_lo(mon_lo), .mask_sel(mask_sel),
        .mod_en(mod_en), .bias_en(bias_en), .loop_pull_low(loop_pull_low),
        .alarm(alarm), .alarm_n(alarm_n)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic logic exp_allow(input logic a, input logic b);
        return !a && b;
    endfunction

    function automatic logic exp_alarm(input logic a, input logic b, input logic hi,
                                       input logic lo, input logic msk);
        return exp_allow(a, b) ? (hi | lo) : msk;
    endfunction

    task automatic chk_en(input string req, input logic exp);
        chk(req, mod_en, exp);
        chk({req, " bias"}, bias_en, exp);
        chk("R3 pull_low", loop_pull_low, !exp);
    endtask

    initial begin
        // R1: reset state
        step(3);
        chk("R1 mod_en", mod_en, 1'b0);
        chk("R1 bias_en", bias_en, 1'b0);
        chk("R1 pull_low", loop_pull_low, 1'b1);
        chk("R1 alarm", alarm, 1'b0);
        chk("R1 alarm_n", alarm_n, 1'b1);
        rst_n = 1'b1;

        // R5: idle out of reset until first data change
        step(10);
        chk_en("R5 idle after reset", 1'b0);

        // R5 recovery and R7 default limit timing
        tx_data = 1'b1;
        step(3);
        chk_en("R5 before recovery", 1'b0);
        step(1);
        chk_en("R5 recovery", 1'b1);
        step(DEF_L + 4 - 4);
        chk_en("R7 default limit edge T+L+3", 1'b1);
        step(1);
        chk_en("R7 default limit edge T+L+4", 1'b0);

        // R7: load a short limit from the port
        limit_load = 1'b1;
        idle_limit = 16'd5;
        step(1);
        limit_load = 1'b0;
        idle_limit = 16'd300;

        // R5: alternating polarity edges keep drive on
        tx_data = 1'b0;
        step(4);
        chk_en("R5 falling edge recovery", 1'b1);
        for (int i = 0; i < 10; i++) begin
            tx_data = ~tx_data;
            step(4);
            chk_en("R5 edges keep drive", 1'b1);
        end
        // R4: exact timeout with L=5
        tx_data = ~tx_data;
        step(5 + 4);
        chk_en("R4 still on at T+L+3", 1'b1);
        step(1);
        chk_en("R4 off at T+L+4", 1'b0);

        // R9: alarm follows mask during idle shutdown
        mon_hi = 1'b0; mon_lo = 1'b0; mask_sel = 1'b1;
        step(1);
        chk("R9 mask high", alarm, 1'b1);
        chk("R10 complement", alarm_n, 1'b0);
        mon_hi = 1'b1; mask_sel = 1'b0;
        step(1);
        chk("R9 mask low", alarm, 1'b0);
        chk("R10 complement", alarm_n, 1'b1);

        // R6: watchdog disabled overrides idle
        wdog_dis = 1'b1;
        step(1);
        chk_en("R6 disable restores drive", 1'b1);
        chk("R8 window high", alarm, 1'b1);
        step(50);
        chk_en("R6 long quiet", 1'b1);

        // R2: full truth table
        for (int k = 0; k < 4; k++) begin
            shdn_a = k[1];
            shdn_b = k[0];
            step(1);
            chk_en("R2 pair table", exp_allow(k[1], k[0]));
        end

        // random phase: watchdog off, check shutdown pair and alarm logic
        begin
            int seed;
            logic pa, pb, ph, pl, pm;
            seed = 12345;
            void'($urandom(seed));
            for (int i = 0; i < 400; i++) begin
                pa = 1'($urandom); pb = 1'($urandom); ph = 1'($urandom);
                pl = 1'($urandom); pm = 1'($urandom);
                shdn_a = pa; shdn_b = pb; mon_hi = ph; mon_lo = pl; mask_sel = pm;
                tx_data = 1'($urandom);
                step(1);
                chk_en("R2 random", exp_allow(pa, pb));
                chk("R8/R9 random alarm", alarm, exp_alarm(pa, pb, ph, pl, pm));
                chk("R10 random", alarm_n, !exp_alarm(pa, pb, ph, pl, pm));
            end
        end

        // R1: reset again mid-run
        rst_n = 1'b0;
        step(1);
        chk_en("R1 reasserted reset", 1'b0);
        chk("R1 alarm_n reset", alarm_n, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule